// File: doc/BRIEF.md
# Audio Output Word Conditioner

This block is the last stage that shapes a digital audio sample before it is serialised. Each time the upstream pipeline presents an 18-bit PCM sample with a valid strobe, the block produces one registered output word. That word is either 16 or 18 bits wide. It holds either the sample itself or a small fixed DC offset code. It can also be bit-inverted.

The offset code stands in for the sample in three cases: the output is muted, initialisation is held, or the upstream synchroniser reports that the sample clock has fallen out of lock. The code is zero when the offset feature is off. When the feature is on, the code is a small positive or negative constant whose encoding depends on the selected width. All controls are static levels. They are captured together with the sample, so one output word always reflects one consistent set of controls.

Top module: `audio_out_condition`

## Requirements
- R1: With `wide_sel` low (16-bit mode), the sample path gives `out_data[15:0] = smp_data[17:2]` and `out_data[17:16] = 0`.
- R2: With `wide_sel` high (18-bit mode), the sample path gives `out_data = smp_data`.
- R3: When the offset path is selected and `ofs_en` is low, the offset code is all zeros whatever `ofs_pos` is.
- R4: With `ofs_en` high and `ofs_pos` high, the offset code is 16'h02AA in 16-bit mode and 18'h02AA8 in 18-bit mode.
- R5: With `ofs_en` high and `ofs_pos` low, the offset code is 16'hFD55 in 16-bit mode and 18'h3D554 in 18-bit mode.
- R6: `mute` high selects the offset code in place of the sample. `ofs_en` alone never replaces the sample.
- R7: `init_n` low selects the offset code in place of the sample.
- R8: `sync_fault` high selects the offset path, and the code it carries still follows `ofs_en`/`ofs_pos`.
- R9: With `dpol` low, the word chosen by the sample/offset selection is bitwise complemented over the active width only (bits 15:0 in 16-bit mode, with bits 17:16 left at zero). With `dpol` high it passes unchanged.
- R10: Data and controls are captured only on a cycle with `smp_valid` high. Between strobes, `out_data` holds its value whatever the inputs do.
- R11: `out_valid` is high exactly one cycle after each `smp_valid` cycle. The matching word appears on `out_data` in that same cycle.
- R12: While reset is asserted, `out_data` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe; captures data and controls |
| smp_data | input | 18 | Input PCM sample, MSB aligned |
| ofs_en | input | 1 | Offset code enable |
| ofs_pos | input | 1 | Offset sign: high positive, low negative |
| wide_sel | input | 1 | Word length: low 16-bit, high 18-bit |
| mute | input | 1 | High forces the offset code |
| init_n | input | 1 | Low forces the offset code |
| dpol | input | 1 | High passes data, low inverts the active bits |
| sync_fault | input | 1 | Synchroniser out-of-window flag; high forces the offset path |
| out_data | output | 18 | Registered output word |
| out_valid | output | 1 | Output word strobe |

## Verification
The bench targets several corner cases, and each has a visible failure signature. It checks inversion of an offset code, where a design that inverted before the selection would emit the uninverted constant. It checks inversion in 16-bit mode, where a full-bus complement would set the two upper bits. It checks a disabled offset under a sync fault, where a design that treated the fault as an enable override would output a non-zero code. The negative 18-bit code is compared to its exact value, so the wrong sign or an encoding that is simply the complement of the positive code shows at once. Control changes between strobes must leave the held word untouched. A design that sampled controls continuously would change the word between strobes.

// File: rtl/aoc_pkg.sv
package aoc_pkg;
  localparam int unsigned WIDE_W   = 18;
  localparam int unsigned NARROW_W = 16;

  typedef enum logic {
    WIDTH_NARROW = 1'b0,
    WIDTH_WIDE   = 1'b1
  } width_e;

  typedef struct packed {
    logic   ofs_en;
    logic   ofs_pos;
    width_e width;
    logic   force_ofs;
    logic   dpol;
  } ctrl_t;
endpackage

// File: rtl/aoc_reset_sync.sv
module aoc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/aoc_offset_gen.sv
module aoc_offset_gen
  import aoc_pkg::*;
#(
  parameter int unsigned               W_WIDE     = WIDE_W,
  parameter int unsigned               W_NARROW   = NARROW_W,
  parameter logic [W_NARROW-1:0]       POS_NARROW = 16'h02AA,
  parameter logic [W_NARROW-1:0]       NEG_NARROW = 16'hFD55,
  parameter logic [W_WIDE-1:0]         POS_WIDE   = 18'h02AA8,
  parameter logic [W_WIDE-1:0]         NEG_WIDE   = 18'h3D554
) (
  input  logic              ofs_en,
  input  logic              ofs_pos,
  input  width_e            width,
  output logic [W_WIDE-1:0] code
);
  localparam int unsigned PAD_W = W_WIDE - W_NARROW;

  logic [W_WIDE-1:0] narrow_code;
  logic [W_WIDE-1:0] wide_code;

  always_comb begin
    narrow_code = {{PAD_W{1'b0}}, (ofs_pos ? POS_NARROW : NEG_NARROW)};
    wide_code   = ofs_pos ? POS_WIDE : NEG_WIDE;
    if (!ofs_en)                  code = '0;
    else if (width == WIDTH_WIDE) code = wide_code;
    else                          code = narrow_code;
  end
endmodule

// File: rtl/aoc_word_mux.sv
module aoc_word_mux
  import aoc_pkg::*;
#(
  parameter int unsigned W_WIDE   = WIDE_W,
  parameter int unsigned W_NARROW = NARROW_W
) (
  input  logic [W_WIDE-1:0] sample,
  input  logic [W_WIDE-1:0] code,
  input  logic              force_ofs,
  input  width_e            width,
  input  logic              dpol,
  output logic [W_WIDE-1:0] word
);
  localparam int unsigned       PAD_W       = W_WIDE - W_NARROW;
  localparam logic [W_WIDE-1:0] NARROW_MASK = {{PAD_W{1'b0}}, {W_NARROW{1'b1}}};

  logic [W_WIDE-1:0] sample_fit;
  logic [W_WIDE-1:0] chosen;
  logic [W_WIDE-1:0] active_mask;

  always_comb begin
    if (width == WIDTH_WIDE) begin
      sample_fit  = sample;
      active_mask = '1;
    end else begin
      sample_fit  = {{PAD_W{1'b0}}, sample[W_WIDE-1 -: W_NARROW]};
      active_mask = NARROW_MASK;
    end
    chosen = force_ofs ? code : sample_fit;
    word   = dpol ? chosen : (~chosen & active_mask);
  end
endmodule

// File: rtl/audio_out_condition.sv
module audio_out_condition
  import aoc_pkg::*;
#(
  parameter int unsigned W_WIDE      = WIDE_W,
  parameter int unsigned W_NARROW    = NARROW_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [W_WIDE-1:0] smp_data,
  input  logic              ofs_en,
  input  logic              ofs_pos,
  input  logic              wide_sel,
  input  logic              mute,
  input  logic              init_n,
  input  logic              dpol,
  input  logic              sync_fault,
  output logic [W_WIDE-1:0] out_data,
  output logic              out_valid
);
  logic              rst_sync_n;
  ctrl_t             ctrl;
  logic [W_WIDE-1:0] ofs_code;
  logic [W_WIDE-1:0] word;
  logic [W_WIDE-1:0] data_d, data_q;
  logic              valid_d, valid_q;

  aoc_reset_sync #(.STAGES(SYNC_STAGES)) rsync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctrl.ofs_en    = ofs_en;
    ctrl.ofs_pos   = ofs_pos;
    ctrl.width     = wide_sel ? WIDTH_WIDE : WIDTH_NARROW;
    ctrl.force_ofs = mute | ~init_n | sync_fault;
    ctrl.dpol      = dpol;
  end

  aoc_offset_gen #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) ofs_i (
    .ofs_en  (ctrl.ofs_en),
    .ofs_pos (ctrl.ofs_pos),
    .width   (ctrl.width),
    .code    (ofs_code)
  );

  aoc_word_mux #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) mux_i (
    .sample    (smp_data),
    .code      (ofs_code),
    .force_ofs (ctrl.force_ofs),
    .width     (ctrl.width),
    .dpol      (ctrl.dpol),
    .word      (word)
  );

  always_comb begin
    valid_d = smp_valid;
    data_d  = smp_valid ? word : data_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign out_data  = data_q;
  assign out_valid = valid_q;

  assert_valid_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    smp_valid |=> out_valid);
  assert_no_valid_without_strobe_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !smp_valid |=> !out_valid);
  assert_hold_between_strobes_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !smp_valid |=> $stable(out_data));
  assert_narrow_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && !wide_sel) |=> (out_data[W_WIDE-1:W_NARROW] == '0));
  assert_wide_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && wide_sel && !mute && init_n && !sync_fault && dpol)
      |=> (out_data == $past(smp_data)));
  assert_disabled_offset_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && (mute || !init_n || sync_fault) && !ofs_en && dpol) |=> (out_data == '0));
endmodule

// File: tb/audio_out_condition_tb_top.sv
module audio_out_condition_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [17:0] smp_data;
  logic        ofs_en, ofs_pos, wide_sel, mute, init_n, dpol, sync_fault;
  logic [17:0] out_data;
  logic        out_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  audio_out_condition dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .ofs_en(ofs_en), .ofs_pos(ofs_pos), .wide_sel(wide_sel), .mute(mute),
    .init_n(init_n), .dpol(dpol), .sync_fault(sync_fault),
    .out_data(out_data), .out_valid(out_valid)
  );

  // {sample, en pos wide mute init_n dpol fault, expected}
  localparam int NV = 20;
  localparam logic [42:0] VEC [NV] = '{
    {18'h25A3C, 7'b0000110, 18'h0968F},  // R1 narrow sample
    {18'h25A3C, 7'b0010110, 18'h25A3C},  // R2 wide sample
    {18'h25A3C, 7'b0010100, 18'h1A5C3},  // R9 wide invert
    {18'h25A3C, 7'b0000100, 18'h06970},  // R9 narrow invert, upper zero
    {18'h25A3C, 7'b1101110, 18'h002AA},  // R4 R6 narrow positive
    {18'h25A3C, 7'b1111110, 18'h02AA8},  // R4 R6 wide positive
    {18'h25A3C, 7'b1001110, 18'h0FD55},  // R5 narrow negative
    {18'h25A3C, 7'b1011110, 18'h3D554},  // R5 wide negative
    {18'h25A3C, 7'b0111110, 18'h00000},  // R3 disabled, pos wide
    {18'h25A3C, 7'b0001110, 18'h00000},  // R3 disabled, neg narrow
    {18'h25A3C, 7'b1110010, 18'h02AA8},  // R7 init low
    {18'h25A3C, 7'b1000010, 18'h0FD55},  // R7 init low narrow negative
    {18'h25A3C, 7'b1110111, 18'h02AA8},  // R8 sync fault
    {18'h25A3C, 7'b0100111, 18'h00000},  // R8 fault with offset off
    {18'h25A3C, 7'b1111100, 18'h3D557},  // R9 inverted wide offset
    {18'h25A3C, 7'b1101100, 18'h0FD55},  // R9 inverted narrow offset
    {18'h25A3C, 7'b0011100, 18'h3FFFF},  // R3 R9 inverted zero code
    {18'h25A3C, 7'b1110110, 18'h25A3C},  // R6 enable alone keeps sample
    {18'h30001, 7'b0000110, 18'h0C000},  // R1 second pattern
    {18'h30001, 7'b0010100, 18'h0FFFE}   // R9 second pattern
  };

  task automatic check(input logic [17:0] act, input logic [17:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [6:0] c);
    {ofs_en, ofs_pos, wide_sel, mute, init_n, dpol, sync_fault} = c;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = 18'h25A3C;
    set_ctrl(7'b1111110);
    repeat (3) @(negedge clk);
    check(out_data, 18'h0, "R12 data in reset");
    check({17'b0, out_valid}, 18'h0, "R12 valid in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({17'b0, out_valid}, 18'h0, "R11 idle after reset");

    for (int i = 0; i < NV; i++) begin
      smp_data = VEC[i][42:25];
      set_ctrl(VEC[i][24:18]);
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      check({17'b0, out_valid}, 18'h1, $sformatf("R11 valid vec %0d", i));
      check(out_data, VEC[i][17:0], $sformatf("vector %0d (see table tag)", i));
      @(negedge clk);
      check({17'b0, out_valid}, 18'h0, $sformatf("R11 single pulse vec %0d", i));
    end

    // R10: inputs move without a strobe; word must hold
    held = out_data;
    smp_data = 18'h00F0F; set_ctrl(7'b1011100);
    repeat (3) @(negedge clk);
    check(out_data, held, "R10 hold with changed inputs");
    set_ctrl(7'b0000110);
    @(negedge clk);
    check(out_data, held, "R10 hold after second change");
    // captured on strobe with current controls
    smp_valid = 1'b1; @(negedge clk); smp_valid = 1'b0;
    check(out_data, 18'h003C3, "R10 R1 capture after hold");

    // R12: reset mid-run clears output
    rst_n = 1'b0; #1;
    check(out_data, 18'h0, "R12 async clear");
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule